// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer With Annul

This block generates fetch addresses for a processor whose instructions all have the same length and whose control transfers each have one delay slot. It holds two program counters. `pc_o` is the address of the instruction now in execute. `fetch_addr_o` is the address that will follow it. Every cycle, the decode stage supplies a description of the instruction at `pc_o`: whether it is a control transfer, what kind it is, the evaluated condition, the annul bit and the target address. One cycle after a transfer is accepted, `pc_o` holds its delay slot and `fetch_addr_o` holds either the target or the fall-through address.

An annul bit lets a conditional branch cancel its delay slot when the branch falls through. This gives a compact "execute the next instruction only if" idiom. An always-taken branch with the annul bit set cancels its slot even though it is taken. A cancelled slot still uses its cycle, but `slot_valid_o` is low so that execute discards it. Either way, both outcomes reach their next address in the same number of cycles.

A control transfer that is decoded inside a live delay slot is not allowed. The sequencer does not redirect for it. It keeps fetching sequentially and sets an error flag that stays set until reset. A transfer decoded inside a cancelled slot has no effect.

Top module: `dbs_sequencer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the sequencer loads the following values, which hold after that edge: `pc_o` = `RESET_VEC`, `fetch_addr_o` = `RESET_VEC` + 4, `slot_valid_o` = 1, `delay_slot_o` = 0, `err_o` = 0.
- R2: At every clock edge out of reset, `pc_o` takes the previous value of `fetch_addr_o`. When no transfer is accepted, `fetch_addr_o` advances by `INSN_BYTES` (4).
- R3: `xfer_kind_i` is encoded as 00 conditional branch, 01 always-taken branch, 10 call, 11 never-taken branch. An accepted transfer that is taken loads the target into `fetch_addr_o` at the next edge, while `pc_o` moves to the delay slot. A transfer is taken when its kind is 01 or 10, or when its kind is 00 with `cond_i` = 1.
- R4: A conditional branch with `annul_i` = 0 leaves its delay slot valid whether it is taken or not. When it is not taken, execution continues at the branch address + 8.
- R5: A conditional branch with `annul_i` = 1 and `cond_i` = 1 leaves its delay slot valid, and execution continues at the target.
- R6: A conditional branch with `annul_i` = 1 and `cond_i` = 0 drives `slot_valid_o` low during its delay slot, and execution continues at the branch address + 8. This takes the same two cycles as the taken case.
- R7: With `annul_i` = 1, an always-taken branch cancels its delay slot and continues at the target. A never-taken branch with `annul_i` = 1 cancels its slot and continues at the branch address + 8.
- R8: A call ignores `annul_i`, so its delay slot is always valid.
- R9: A transfer decoded while `pc_o` holds a valid delay slot is not redirected. At the next edge `err_o` is set and it stays set until reset.
- R10: A transfer decoded while `slot_valid_o` is 0 has no effect. It causes no redirect, no error and no cancellation.
- R11: The low log2(`INSN_BYTES`) bits of `target_i` are ignored, so `fetch_addr_o` is always a multiple of `INSN_BYTES`.
- R12: `delay_slot_o` is 1 exactly in the cycle after an accepted transfer. A delay slot is never followed directly by another delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| xfer_valid_i | input | 1 | Instruction at `pc_o` is a control transfer |
| xfer_kind_i | input | 2 | Transfer kind: 00 cond, 01 always, 10 call, 11 never |
| cond_i | input | 1 | Evaluated branch condition |
| annul_i | input | 1 | Annul bit of the branch |
| target_i | input | AW | Transfer target address |
| pc_o | output | AW | Address of the instruction in execute |
| fetch_addr_o | output | AW | Next program counter, used as the fetch address |
| slot_valid_o | output | 1 | Instruction at `pc_o` may commit; 0 means it is cancelled |
| delay_slot_o | output | 1 | Instruction at `pc_o` is a delay slot |
| err_o | output | 1 | Sticky flag for a transfer inside a delay slot |

## Verification
A decoded control transfer can arrive in the same cycle that the sequencer is handling the delay slot of an earlier transfer. The slot can then be live or cancelled, and the two states have different outcomes. The bench provokes both cases by placing a call inside the slot of an always-taken branch and inside the cancelled slot of an annulled branch that falls through. In each case it checks, one edge later, that the fetch address followed the first transfer rather than the call. It also checks that `err_o` was set only for the live slot and stays set while execution continues sequentially.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [1:0] {
      XK_COND   = 2'b00,
      XK_ALWAYS = 2'b01,
      XK_CALL   = 2'b10,
      XK_NEVER  = 2'b11
   } xfer_kind_e;

   typedef struct packed {
      logic legal;     // transfer accepted outside a live slot
      logic redirect;  // accepted and taken
      logic squash;    // cancel the coming delay slot
      logic clash;     // transfer found inside a live slot
   } xfer_dec_t;

endpackage

// File: rtl/dbs_resolve.sv
module dbs_resolve
   import dbs_pkg::*;
(
   input  logic       xfer_valid_i,
   input  logic [1:0] xfer_kind_i,
   input  logic       cond_i,
   input  logic       annul_i,
   input  logic       live_i,
   input  logic       in_slot_i,
   output xfer_dec_t  dec_o
);

   xfer_kind_e kind;
   logic       active;
   logic       taken;
   logic       annul_ok;

   assign kind   = xfer_kind_e'(xfer_kind_i);
   // a cancelled instruction must not act, whatever it decodes to
   assign active = xfer_valid_i & live_i;

   always_comb begin
      taken    = 1'b0;
      annul_ok = 1'b0;
      unique case (kind)
         XK_COND: begin
            taken    = cond_i;
            annul_ok = ~cond_i;
         end
         XK_ALWAYS: begin
            taken    = 1'b1;
            annul_ok = 1'b1;
         end
         XK_CALL: begin
            taken    = 1'b1;
            annul_ok = 1'b0;
         end
         XK_NEVER: begin
            taken    = 1'b0;
            annul_ok = 1'b1;
         end
         default: begin
            taken    = 1'b0;
            annul_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      dec_o.legal    = active & ~in_slot_i;
      dec_o.clash    = active & in_slot_i;
      dec_o.redirect = dec_o.legal & taken;
      dec_o.squash   = dec_o.legal & annul_i & annul_ok;
   end

endmodule

// File: rtl/dbs_pc_regs.sv
module dbs_pc_regs #(
   parameter int           AW           = 32,
   parameter int           INSN_BYTES   = 4,
   parameter bit           ALIGN_TARGET = 1'b1,
   parameter logic [AW-1:0] RESET_VEC   = 'h100
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          redirect_i,
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] npc_o
);

   localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
   localparam logic [AW-1:0] LOW_MASK = AW'(INSN_BYTES - 1);

   logic [AW-1:0] tgt_use;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] npc_q;

   generate
      if (ALIGN_TARGET) begin : g_align
         assign tgt_use = target_i & ~LOW_MASK;
      end else begin : g_raw
         assign tgt_use = target_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q  <= RESET_VEC;
         npc_q <= RESET_VEC + STEP;
      end else begin
         pc_q  <= npc_q;
         npc_q <= redirect_i ? tgt_use : (npc_q + STEP);
      end
   end

   assign pc_o  = pc_q;
   assign npc_o = npc_q;

endmodule

// File: rtl/dbs_slot_state.sv
module dbs_slot_state
   import dbs_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  xfer_dec_t dec_i,
   output logic      live_o,
   output logic      in_slot_o,
   output logic      err_o
);

   logic live_q;
   logic in_slot_q;
   logic err_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         live_q    <= 1'b1;
         in_slot_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         live_q    <= ~dec_i.squash;
         in_slot_q <= dec_i.legal;
         err_q     <= err_q | dec_i.clash;
      end
   end

   assign live_o    = live_q;
   assign in_slot_o = in_slot_q;
   assign err_o     = err_q;

endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
   import dbs_pkg::*;
#(
   parameter int            AW           = 32,
   parameter int            INSN_BYTES   = 4,
   parameter bit            ALIGN_TARGET = 1'b1,
   parameter logic [AW-1:0] RESET_VEC    = 'h100
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          xfer_valid_i,
   input  logic [1:0]    xfer_kind_i,
   input  logic          cond_i,
   input  logic          annul_i,
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] fetch_addr_o,
   output logic          slot_valid_o,
   output logic          delay_slot_o,
   output logic          err_o
);

   localparam int OFS_W = $clog2(INSN_BYTES);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("dbs_sequencer: AW must be at least 8");
      end
      if (INSN_BYTES < 2 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_step
         $error("dbs_sequencer: INSN_BYTES must be a power of two, at least 2");
      end
      if ((RESET_VEC & AW'(INSN_BYTES - 1)) != '0) begin : g_bad_vec
         $error("dbs_sequencer: RESET_VEC must be instruction aligned");
      end
      if (OFS_W >= AW) begin : g_bad_ofs
         $error("dbs_sequencer: INSN_BYTES too large for AW");
      end
   endgenerate

   xfer_dec_t dec;
   logic      live;
   logic      in_slot;

   dbs_resolve u_resolve (
      .xfer_valid_i (xfer_valid_i),
      .xfer_kind_i  (xfer_kind_i),
      .cond_i       (cond_i),
      .annul_i      (annul_i),
      .live_i       (live),
      .in_slot_i    (in_slot),
      .dec_o        (dec)
   );

   dbs_pc_regs #(
      .AW           (AW),
      .INSN_BYTES   (INSN_BYTES),
      .ALIGN_TARGET (ALIGN_TARGET),
      .RESET_VEC    (RESET_VEC)
   ) u_pc (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .redirect_i (dec.redirect),
      .target_i   (target_i),
      .pc_o       (pc_o),
      .npc_o      (fetch_addr_o)
   );

   dbs_slot_state u_state (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .dec_i     (dec),
      .live_o    (live),
      .in_slot_o (in_slot),
      .err_o     (err_o)
   );

   assign slot_valid_o = live;
   assign delay_slot_o = in_slot;

endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
   parameter int AW         = 32,
   parameter int INSN_BYTES = 4
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          xfer_valid_i,
   input logic [1:0]    xfer_kind_i,
   input logic [AW-1:0] target_i,
   input logic [AW-1:0] pc_o,
   input logic [AW-1:0] fetch_addr_o,
   input logic          slot_valid_o,
   input logic          delay_slot_o,
   input logic          err_o
);

   localparam int OFS_W = $clog2(INSN_BYTES);

   a_r2_pc_follows_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> pc_o == $past(fetch_addr_o));

   a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rst_i && err_o) |=> err_o);

   a_r6_squash_only_in_slot: assert property (@(posedge clk_i) disable iff (rst_i)
      !slot_valid_o |-> delay_slot_o);

   a_r12_no_back_to_back_slot: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rst_i && delay_slot_o) |=> !delay_slot_o);

   a_r3_call_redirects: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rst_i && xfer_valid_i && slot_valid_o && !delay_slot_o && xfer_kind_i == 2'b10)
      |=> (((fetch_addr_o ^ $past(target_i)) >> OFS_W) == '0) && delay_slot_o);

   a_r8_call_slot_live: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rst_i && xfer_valid_i && slot_valid_o && !delay_slot_o && xfer_kind_i == 2'b10)
      |=> slot_valid_o);

   a_r11_fetch_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |-> fetch_addr_o[OFS_W-1:0] == '0);

   a_r1_pc_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |-> pc_o[OFS_W-1:0] == '0);

endmodule

bind dbs_sequencer dbs_sequencer_chk #(
   .AW         (AW),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .xfer_valid_i (xfer_valid_i),
   .xfer_kind_i  (xfer_kind_i),
   .target_i     (target_i),
   .pc_o         (pc_o),
   .fetch_addr_o (fetch_addr_o),
   .slot_valid_o (slot_valid_o),
   .delay_slot_o (delay_slot_o),
   .err_o        (err_o)
);

// File: tb/dbs_sequencer_tb_top.sv
`timescale 1ns/1ps
module dbs_sequencer_tb_top;

   localparam int          AW  = 32;
   localparam logic [31:0] VEC = 32'h100;

   logic          clk = 1'b0;
   logic          rst_i;
   logic          xfer_valid_i;
   logic [1:0]    xfer_kind_i;
   logic          cond_i;
   logic          annul_i;
   logic [AW-1:0] target_i;
   logic [AW-1:0] pc_o;
   logic [AW-1:0] fetch_addr_o;
   logic          slot_valid_o;
   logic          delay_slot_o;
   logic          err_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   dbs_sequencer #(.AW(AW), .INSN_BYTES(4), .RESET_VEC(VEC)) dut_i (
      .clk_i        (clk),
      .rst_i        (rst_i),
      .xfer_valid_i (xfer_valid_i),
      .xfer_kind_i  (xfer_kind_i),
      .cond_i       (cond_i),
      .annul_i      (annul_i),
      .target_i     (target_i),
      .pc_o         (pc_o),
      .fetch_addr_o (fetch_addr_o),
      .slot_valid_o (slot_valid_o),
      .delay_slot_o (delay_slot_o),
      .err_o        (err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      xfer_valid_i = 1'b0;
      xfer_kind_i  = 2'b00;
      cond_i       = 1'b0;
      annul_i      = 1'b0;
      target_i     = '0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_i = 1'b1;
      repeat (2) @(negedge clk);
      rst_i = 1'b0;
   endtask

   task automatic drive_xfer(input logic [1:0] kind, input logic c, input logic a,
                             input logic [31:0] tgt);
      xfer_valid_i = 1'b1;
      xfer_kind_i  = kind;
      cond_i       = c;
      annul_i      = a;
      target_i     = tgt;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 pc", pc_o, VEC);
      chk("R1 fetch", fetch_addr_o, VEC + 32'd4);
      chk("R1 slot_valid", {31'd0, slot_valid_o}, 32'd1);
      chk("R1 delay_slot", {31'd0, delay_slot_o}, 32'd0);
      chk("R1 err", {31'd0, err_o}, 32'd0);
   endtask

   task automatic t_sequential();
      do_reset();
      repeat (3) @(negedge clk);
      chk("R2 pc after 3", pc_o, VEC + 32'd12);
      chk("R2 fetch after 3", fetch_addr_o, VEC + 32'd16);
      chk("R2 valid", {31'd0, slot_valid_o}, 32'd1);
   endtask

   // branch at VEC; slot at VEC+4; next at 0x200 (taken) or VEC+8
   task automatic t_branch(input string tag, input logic [1:0] kind, input logic c,
                           input logic a, input logic [31:0] tgt,
                           input logic exp_live, input logic exp_taken);
      logic [31:0] dest;
      dest = exp_taken ? 32'h200 : VEC + 32'd8;
      do_reset();
      drive_xfer(kind, c, a, tgt);
      @(negedge clk);
      idle_inputs();
      chk({tag, " slot pc"}, pc_o, VEC + 32'd4);
      chk({tag, " R12 slot marker"}, {31'd0, delay_slot_o}, 32'd1);
      chk({tag, " slot valid"}, {31'd0, slot_valid_o}, {31'd0, exp_live});
      chk({tag, " fetch"}, fetch_addr_o, dest);
      @(negedge clk);
      chk({tag, " next pc"}, pc_o, dest);
      chk({tag, " next valid"}, {31'd0, slot_valid_o}, 32'd1);
      chk({tag, " R12 marker clear"}, {31'd0, delay_slot_o}, 32'd0);
   endtask

   task automatic t_xfer_in_live_slot();
      do_reset();
      drive_xfer(2'b01, 1'b0, 1'b0, 32'h200);
      @(negedge clk);
      drive_xfer(2'b10, 1'b0, 1'b0, 32'h300);   // call inside live slot
      chk("R9 err before", {31'd0, err_o}, 32'd0);
      @(negedge clk);
      idle_inputs();
      chk("R9 pc at first target", pc_o, 32'h200);
      chk("R9 no second redirect", fetch_addr_o, 32'h204);
      chk("R9 err set", {31'd0, err_o}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R9 err sticky", {31'd0, err_o}, 32'd1);
      chk("R9 sequential", pc_o, 32'h20C);
   endtask

   task automatic t_xfer_in_dead_slot();
      do_reset();
      drive_xfer(2'b00, 1'b0, 1'b1, 32'h200);
      @(negedge clk);
      chk("R10 slot cancelled", {31'd0, slot_valid_o}, 32'd0);
      drive_xfer(2'b10, 1'b0, 1'b0, 32'h300);   // call inside cancelled slot
      @(negedge clk);
      idle_inputs();
      chk("R10 pc", pc_o, VEC + 32'd8);
      chk("R10 fetch", fetch_addr_o, VEC + 32'd12);
      chk("R10 err clear", {31'd0, err_o}, 32'd0);
      chk("R10 no slot", {31'd0, delay_slot_o}, 32'd0);
      chk("R10 valid", {31'd0, slot_valid_o}, 32'd1);
   endtask

   initial begin
      idle_inputs();
      rst_i = 1'b1;
      t_reset();
      t_sequential();
      t_branch("R3 cond taken",          2'b00, 1'b1, 1'b0, 32'h200, 1'b1, 1'b1);
      t_branch("R4 cond untaken",        2'b00, 1'b0, 1'b0, 32'h200, 1'b1, 1'b0);
      t_branch("R5 annul taken",         2'b00, 1'b1, 1'b1, 32'h200, 1'b1, 1'b1);
      t_branch("R6 annul untaken",       2'b00, 1'b0, 1'b1, 32'h200, 1'b0, 1'b0);
      t_branch("R7 always annul",        2'b01, 1'b0, 1'b1, 32'h200, 1'b0, 1'b1);
      t_branch("R7 never annul",         2'b11, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0);
      t_branch("R8 call annul ignored",  2'b10, 1'b0, 1'b1, 32'h200, 1'b1, 1'b1);
      t_branch("R11 unaligned target",   2'b01, 1'b0, 1'b0, 32'h203, 1'b1, 1'b1);
      t_xfer_in_live_slot();
      t_xfer_in_dead_slot();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule